// File: doc/BRIEF.md
# Shifter Operand Unit

This block forms the second operand for an integer ALU, together with the carry that the shifter hands to the flag logic. A 12-bit operand field and a two-bit mode select pick one of three ways to form the operand. The first is an 8-bit constant rotated right by an even amount. The second is a register value shifted by a 5-bit amount taken from the field. The third is a register value shifted by an amount held in a second register. The shift kinds are logical left, logical right, arithmetic right, rotate right, and a one-bit rotate through the carry flag.

The shift function itself is combinational. A single register stage wraps it, so that the operand, the carry and a valid flag all appear one clock after their inputs. The block fetches no operands and does no arithmetic.

Top module: `shifter_operand_unit`

## Requirements
- R1: While `rstN` is low, `outValid`, `operand` and `carryOut` are all zero.
- R2: Each result appears one clock after its inputs, and `outValid` equals `inValid` from the previous clock.
- R3: With `modeSel`=00, `operand` is `{24'b0, opField[7:0]}` rotated right by 2×`opField[11:8]`. `carryOut` is bit 31 of that operand when `opField[11:8]` is nonzero, and `carryIn` otherwise.
- R4: The register modes take the shift kind from `opField[6:5]`: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. `modeSel`=01 takes the amount from `opField[11:7]`, and `modeSel`=11 behaves exactly like 01. `modeSel`=10 takes the amount from `shiftRegByte`.
- R5: A logical left shift by an immediate amount of 0 passes `rmValue` through unchanged, and `carryOut` equals `carryIn`.
- R6: A logical right or arithmetic right shift with an immediate amount of 0 shifts by 32. Logical right then gives 0; arithmetic right gives 32 copies of `rmValue[31]`. In both cases `carryOut` is `rmValue[31]`.
- R7: A rotate right with an immediate amount of 0 is a 33-bit rotate through carry. `operand` is `{carryIn, rmValue[31:1]}` and `carryOut` is `rmValue[0]`.
- R8: A register amount of 0 passes `rmValue` through with `carryOut` equal to `carryIn`, whatever the shift kind.
- R9: A register logical shift by exactly 32 gives 0. `carryOut` is then `rmValue[0]` for left and `rmValue[31]` for right. By more than 32, both the operand and `carryOut` are 0.
- R10: A register arithmetic right shift by 32 or more fills every bit with `rmValue[31]`, and `carryOut` is `rmValue[31]`.
- R11: A register rotate by a nonzero multiple of 32 leaves `rmValue` unchanged, with `carryOut` equal to `rmValue[31]`. Any other nonzero amount rotates by the amount modulo 32, and `carryOut` is bit 31 of the result.
- R12: For shift amounts from 1 to 31, vacated bits fill with zeros, or with the sign bit for arithmetic right. `carryOut` is the last bit shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Inputs carry a request this cycle |
| modeSel | input | 2 | 00 rotated constant, 01/11 shift by field amount, 10 shift by register amount |
| opField | input | 12 | Operand field of the instruction |
| rmValue | input | 32 | Register value to be shifted |
| shiftRegByte | input | 8 | Low byte of the amount register |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | Registered request flag |
| operand | output | 32 | Registered shifted operand |
| carryOut | output | 1 | Registered shifter carry |

## Verification
Every result, together with `outValid`, is due exactly one clock after its inputs; no result is ever due in the cycle of its own inputs. The bench drives new inputs on each falling edge. On the next falling edge it compares the outputs with the expectation it computed for the inputs of the cycle before, so one check is in flight at a time. The reference model shifts one bit per loop step and tracks the carry as it goes. It exercises the amounts 0, 1, 31, 32, 33 and 255 and both sign polarities, followed by a run of random fields.

// File: rtl/shop_pkg.sv
package shop_pkg;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 12;
  localparam int AMT_W   = 8;
  localparam int IMM_W   = 8;
  localparam int ROT_W   = 4;
  localparam int SH5_W   = 5;
  localparam int CAP_W   = $clog2(DATA_W + 2);

  typedef enum logic [2:0] {
    K_LSL, K_LSR, K_ASR, K_ROR, K_RRX, K_ROTIMM
  } shiftKindT;

  // strobes from control to datapath
  typedef struct packed {
    shiftKindT        kind;
    logic [AMT_W-1:0] amount;
    logic             useImm;
  } ctrlT;
endpackage

// File: rtl/shop_ctrl.sv
module shop_ctrl
  import shop_pkg::*;
(
  input  logic [1:0]         modeSel,
  input  logic [FIELD_W-1:0] opField,
  input  logic [AMT_W-1:0]   shiftRegByte,
  output ctrlT               ctrl
);
  logic [SH5_W-1:0] imm5;
  logic [1:0]       typ;

  assign imm5 = opField[FIELD_W-1 -: SH5_W];
  assign typ  = opField[6:5];

  always_comb begin
    ctrl.kind   = K_LSL;
    ctrl.amount = '0;
    ctrl.useImm = 1'b0;
    unique case (modeSel)
      2'b00: begin
        ctrl.kind   = K_ROTIMM;
        ctrl.useImm = 1'b1;
        ctrl.amount = AMT_W'({opField[FIELD_W-1 -: ROT_W], 1'b0});
      end
      2'b10: begin
        ctrl.kind   = shiftKindT'({1'b0, typ});
        ctrl.amount = shiftRegByte;
      end
      default: begin
        unique case (typ)
          2'b00: begin
            ctrl.kind   = K_LSL;
            ctrl.amount = AMT_W'(imm5);
          end
          2'b01, 2'b10: begin
            ctrl.kind   = (typ == 2'b01) ? K_LSR : K_ASR;
            ctrl.amount = (imm5 == '0) ? AMT_W'(DATA_W) : AMT_W'(imm5);
          end
          default: begin
            ctrl.kind   = (imm5 == '0) ? K_RRX : K_ROR;
            ctrl.amount = (imm5 == '0) ? AMT_W'(1) : AMT_W'(imm5);
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/shop_datapath.sv
module shop_datapath
  import shop_pkg::*;
(
  input  ctrlT              ctrl,
  input  logic [IMM_W-1:0]  immByte,
  input  logic [DATA_W-1:0] rmValue,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);
  logic [DATA_W-1:0]   src;
  logic [CAP_W-1:0]    logCap;
  logic [CAP_W-1:0]    asrCap;
  logic [DATA_W:0]     lslWide;
  logic [DATA_W:0]     lsrWide;
  logic signed [DATA_W:0] asrIn;
  logic signed [DATA_W:0] asrWide;
  logic [2*DATA_W-1:0] rorWide;

  assign src = ctrl.useImm ? {{(DATA_W-IMM_W){1'b0}}, immByte} : rmValue;

  // amounts past 32 saturate: logical shifts empty out, arithmetic fills sign
  assign logCap = (ctrl.amount > AMT_W'(DATA_W)) ? CAP_W'(DATA_W + 1) : CAP_W'(ctrl.amount);
  assign asrCap = (ctrl.amount >= AMT_W'(DATA_W)) ? CAP_W'(DATA_W) : CAP_W'(ctrl.amount);

  assign lslWide = {1'b0, src} << logCap;
  assign lsrWide = {src, 1'b0} >> logCap;
  assign asrIn   = {src, 1'b0};
  assign asrWide = asrIn >>> asrCap;
  assign rorWide = {src, src} >> ctrl.amount[SH5_W-1:0];

  always_comb begin
    result   = src;
    carryOut = carryIn;
    if (ctrl.kind == K_RRX) begin
      result   = {carryIn, src[DATA_W-1:1]};
      carryOut = src[0];
    end else if (ctrl.amount != '0) begin
      unique case (ctrl.kind)
        K_LSL: {carryOut, result} = lslWide;
        K_LSR: {result, carryOut} = lsrWide;
        K_ASR: {result, carryOut} = asrWide;
        default: begin
          result   = rorWide[DATA_W-1:0];
          carryOut = rorWide[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
  import shop_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [1:0]         modeSel,
  input  logic [FIELD_W-1:0] opField,
  input  logic [DATA_W-1:0]  rmValue,
  input  logic [AMT_W-1:0]   shiftRegByte,
  input  logic               carryIn,
  output logic               outValid,
  output logic [DATA_W-1:0]  operand,
  output logic               carryOut
);
  ctrlT              ctrl;
  logic [DATA_W-1:0] nextOperand;
  logic              nextCarry;

  shop_ctrl u_ctrl (
    .modeSel      (modeSel),
    .opField      (opField),
    .shiftRegByte (shiftRegByte),
    .ctrl         (ctrl)
  );

  shop_datapath u_dp (
    .ctrl     (ctrl),
    .immByte  (opField[IMM_W-1:0]),
    .rmValue  (rmValue),
    .carryIn  (carryIn),
    .result   (nextOperand),
    .carryOut (nextCarry)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      operand  <= '0;
      carryOut <= 1'b0;
    end else begin
      outValid <= inValid;
      operand  <= nextOperand;
      carryOut <= nextCarry;
    end
  end
endmodule

// File: rtl/shifter_operand_checker.sv
module shifter_operand_checker
  import shop_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [1:0]         modeSel,
  input logic [FIELD_W-1:0] opField,
  input logic [DATA_W-1:0]  rmValue,
  input logic [AMT_W-1:0]   shiftRegByte,
  input logic               carryIn,
  input logic               outValid,
  input logic [DATA_W-1:0]  operand,
  input logic               carryOut
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && operand == '0 && !carryOut));

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> outValid == $past(inValid));

  assert_imm_norot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b00 && opField[11:8] == 4'd0) |=>
      (operand == {24'd0, $past(opField[7:0])} && carryOut == $past(carryIn)));

  assert_rrx_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b01 && opField[11:7] == 5'd0 && opField[6:5] == 2'b11) |=>
      (operand == {$past(carryIn), $past(rmValue[31:1])} && carryOut == $past(rmValue[0])));

  assert_reg_zero_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b10 && shiftRegByte == 8'd0) |=>
      (operand == $past(rmValue) && carryOut == $past(carryIn)));

  assert_lsl_over_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b10 && opField[6:5] == 2'b00 && shiftRegByte > 8'd32) |=>
      (operand == '0 && !carryOut));

  assert_asr_fill_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b10 && opField[6:5] == 2'b10 && shiftRegByte >= 8'd32) |=>
      (operand == {32{$past(rmValue[31])}} && carryOut == $past(rmValue[31])));
endmodule

bind shifter_operand_unit shifter_operand_checker u_chk (.*);

// File: tb/shifter_operand_unit_bench.sv
`timescale 1ns/1ps
module shifter_operand_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  modeSel = '0;
  logic [11:0] opField = '0;
  logic [31:0] rmValue = '0;
  logic [7:0]  shiftRegByte = '0;
  logic        carryIn = 1'b0;
  logic        outValid;
  logic [31:0] operand;
  logic        carryOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shifter_operand_unit u_shifter_operand_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeSel(modeSel),
    .opField(opField), .rmValue(rmValue), .shiftRegByte(shiftRegByte),
    .carryIn(carryIn), .outValid(outValid), .operand(operand), .carryOut(carryOut)
  );

  // expectation for the inputs driven one clock earlier
  bit          havePend = 1'b0;
  logic [31:0] expOp;
  logic        expC;
  logic        expV;
  string       expTag;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-bit-per-step reference model
  task automatic model(input logic [1:0] m, input logic [11:0] f, input logic [31:0] rm,
                       input logic [7:0] rs, input logic ci,
                       output logic [31:0] v, output logic c, output string tag);
    int amt;
    int kind;
    v = rm; c = ci;
    if (m == 2'b00) begin
      v = {24'd0, f[7:0]};
      amt = 2 * int'(f[11:8]);
      for (int i = 0; i < amt; i++) v = {v[0], v[31:1]};
      if (amt != 0) c = v[31];
      tag = "R3";
      return;
    end
    kind = int'(f[6:5]);
    if (m == 2'b10) begin
      amt = int'(rs);
      if (amt == 0) tag = "R8";
      else if (kind == 3) tag = "R11";
      else if (kind == 2 && amt >= 32) tag = "R10";
      else if (amt >= 32) tag = "R9";
      else tag = "R12";
    end else begin
      amt = int'(f[11:7]);
      tag = (m == 2'b11) ? "R4" : "R12";
      if (amt == 0) begin
        if (kind == 0) tag = "R5";
        else if (kind == 3) begin
          c = rm[0]; v = {ci, rm[31:1]}; tag = "R7";
          return;
        end else begin
          amt = 32; tag = "R6";
        end
      end
    end
    for (int i = 0; i < amt; i++) begin
      case (kind)
        0: begin c = v[31]; v = v << 1; end
        1: begin c = v[0];  v = v >> 1; end
        2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
  endtask

  task automatic step(input logic v, input logic [1:0] m, input logic [11:0] f,
                      input logic [31:0] rm, input logic [7:0] rs, input logic ci);
    @(negedge clk);
    if (havePend) begin
      check(outValid == expV, "R2", 64'(outValid), 64'(expV));
      check(operand == expOp && carryOut == expC, expTag,
            {31'd0, carryOut, operand}, {31'd0, expC, expOp});
    end
    inValid = v; modeSel = m; opField = f; rmValue = rm; shiftRegByte = rs; carryIn = ci;
    model(m, f, rm, rs, ci, expOp, expC, expTag);
    expV = v;
    havePend = 1'b1;
  endtask

  initial begin
    #900000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs clear even with active inputs
    inValid = 1'b1; modeSel = 2'b10; rmValue = 32'hFFFF_FFFF; carryIn = 1'b1; shiftRegByte = 8'd0;
    repeat (4) begin
      @(negedge clk);
      check(!outValid && operand == '0 && !carryOut, "R1", {31'd0, carryOut, operand}, 64'd0);
    end
    rstN = 1'b1;
    // R3 rotated constants
    step(1, 2'b00, 12'h0AB, 32'h0, 8'h0, 1'b1);
    step(1, 2'b00, 12'h1FF, 32'h0, 8'h0, 1'b0);
    step(1, 2'b00, 12'h4F0, 32'h0, 8'h0, 1'b1);
    step(1, 2'b00, 12'hF81, 32'h0, 8'h0, 1'b1);
    // R5 / R6 / R7 immediate zero encodings
    step(1, 2'b01, {5'd0, 2'b00, 5'd0}, 32'h8000_0001, 8'h0, 1'b1);
    step(1, 2'b01, {5'd0, 2'b01, 5'd0}, 32'h8000_0001, 8'h0, 1'b0);
    step(1, 2'b01, {5'd0, 2'b10, 5'd0}, 32'h8000_0001, 8'h0, 1'b0);
    step(1, 2'b01, {5'd0, 2'b10, 5'd0}, 32'h7000_0000, 8'h0, 1'b1);
    step(0, 2'b01, {5'd0, 2'b11, 5'd0}, 32'h0000_0003, 8'h0, 1'b1);
    step(1, 2'b01, {5'd0, 2'b11, 5'd0}, 32'h8000_0002, 8'h0, 1'b0);
    // R12 / R4 immediate amounts 1 and 31
    step(1, 2'b01, {5'd1, 2'b00, 5'd0}, 32'hC000_0000, 8'h0, 1'b0);
    step(1, 2'b11, {5'd31, 2'b10, 5'd0}, 32'h8000_0000, 8'h0, 1'b0);
    step(1, 2'b11, {5'd4, 2'b11, 5'd0}, 32'h1234_5678, 8'h0, 1'b0);
    // R8 register amount zero, each kind
    for (int k = 0; k < 4; k++)
      step(1, 2'b10, {5'd9, 2'(k), 5'd0}, 32'hDEAD_BEEF, 8'd0, 1'(k));
    // R9 / R10 / R11 register amounts at and past the word
    for (int k = 0; k < 4; k++) begin
      step(1, 2'b10, {5'd0, 2'(k), 5'd0}, 32'h8000_0001, 8'd32, 1'b0);
      step(1, 2'b10, {5'd0, 2'(k), 5'd0}, 32'h8000_0001, 8'd33, 1'b1);
      step(1, 2'b10, {5'd0, 2'(k), 5'd0}, 32'h4000_0003, 8'd255, 1'b1);
      step(1, 2'b10, {5'd0, 2'(k), 5'd0}, 32'h9000_0001, 8'd64, 1'b1);
      step(1, 2'b10, {5'd0, 2'(k), 5'd0}, 32'hF0F0_1234, 8'd31, 1'b0);
    end
    for (int n = 0; n < 400; n++) begin
      logic [7:0] rs;
      rs = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 40)) : 8'($urandom);
      step(1'($urandom), 2'($urandom), 12'($urandom), $urandom, rs, 1'($urandom));
    end
    step(0, 2'b00, 12'h0, 32'h0, 8'h0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule